// File: doc/BRIEF.md
# Multi-Channel Tick Timer Table

This block holds a bank of sixteen countdown channels that share one global tick. A programmable prescaler turns the system clock into that tick, and a global run bit gates it. Software can therefore set up every channel while the bank is halted and then start all of them on the same clock edge. Each channel is configured by writing one command word, not through a register set of its own. The word names the channel and gives it an enable flag, a one-shot or auto-restart mode and a timeout counted in ticks.

A channel that reaches its timeout raises a sticky bit in an event register, and software clears that bit by writing a one to it. A mask register selects which event bits may drive the single interrupt line. A shared tick counter records how many ticks have occurred, and any write to it returns it to zero. All registers sit on a simple synchronous bus: a write takes effect on the rising clock edge, and read data is a combinational function of the address.

Top module: `tick_timer_table`

## Requirements
- R1: After reset the control (address 0), event (address 2), mask (address 3) and tick-count (address 4) registers all read zero, and `irq` is low.
- R2: The control register holds the run bit at bit 0 and a divider D at bits [31:16]. While run is set, a tick occurs every D+1 clocks. A channel with period P therefore sets its event bit exactly P*(D+1) rising edges after the edge that wrote run.
- R3: While run is clear no ticks occur. Enabled channels do not advance, and the tick counter holds its value.
- R4: A write to address 1 issues a command with these fields: bits [3:0] channel number, bit 4 enable, bit 5 restart mode (1 = auto-restart, 0 = one-shot), bits [31:16] period in ticks. An enabling command starts the channel counting from zero.
- R5: A disabling command (bit 4 = 0) stops the addressed channel and ignores the mode and period fields, so that channel raises no event afterwards.
- R6: Channel k owns bit k of the event register and of the mask register. An expiry sets only that channel's event bit.
- R7: Writing to the event register clears each bit written as one and leaves each bit written as zero unchanged. An expiry in the same cycle as a clear of that bit leaves the bit set.
- R8: An auto-restart channel reloads on expiry and expires again every P ticks. A one-shot channel expires once and then stops.
- R9: `irq` is high exactly while some event bit and its mask bit are both one, and it stays high until those event bits are cleared or masked.
- R10: The tick counter at address 4 adds one on every tick. Any write to it sets it to zero, and the write takes priority over a tick in the same cycle.
- R11: A command that arrives in the same cycle as a tick takes priority for the addressed channel. The tick does not advance that channel, and the channel restarts from zero with the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt: OR of masked event bits |

## Verification
The bench targets the places where an off-by-one hides. It counts the exact edge on which each event appears across several divider and period pairs; a prescaler or compare that is off by one misses the check by a cycle. It also issues a command on a cycle that already carries a tick; a design that let the tick win would fire one tick early or late. It further checks that a zero written to the event register keeps the bit, that a disable command carrying a period starts nothing, and that clearing run freezes both channels and the tick counter; designs that got these wrong would drop a pending event, start a channel, or keep counting.

// File: rtl/ttt_pkg.sv
package ttt_pkg;

    localparam int NUM_TMR  = 16;
    localparam int PERIOD_W = 16;
    localparam int DIV_W    = 16;
    localparam int TCNT_W   = 16;
    localparam int ID_W     = $clog2(NUM_TMR);
    localparam int BUS_W    = 32;

    // register addresses
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_CMD   = 3'd1;
    localparam logic [2:0] A_EVT   = 3'd2;
    localparam logic [2:0] A_MASK  = 3'd3;
    localparam logic [2:0] A_TICKS = 3'd4;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic                restart;
        logic                enable;
        logic [ID_W-1:0]     id;
    } tmr_cmd_t;

    typedef struct packed {
        logic                active;
        logic                restart;
        logic [PERIOD_W-1:0] period;
        logic [PERIOD_W-1:0] count;
    } chan_state_t;

    function automatic tmr_cmd_t decode_cmd(input logic [BUS_W-1:0] w);
        tmr_cmd_t c;
        c.period  = w[BUS_W-1 -: PERIOD_W];
        c.restart = w[5];
        c.enable  = w[4];
        c.id      = w[ID_W-1:0];
        return c;
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.div = w[BUS_W-1 -: DIV_W];
        c.run = w[0];
        return c;
    endfunction

endpackage

// File: rtl/ttt_prescaler.sv
module ttt_prescaler #(
    parameter int DIV_W = ttt_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt_q;

    // >= keeps the tick alive if the divider is lowered mid-count
    assign tick = run && (pcnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ttt_channel.sv
module ttt_channel
    import ttt_pkg::*;
#(
    parameter int PW = ttt_pkg::PERIOD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          cmd_hit,
    input  logic          cmd_en,
    input  logic          cmd_restart,
    input  logic [PW-1:0] cmd_period,
    output logic          expire
);
    chan_state_t st_q;
    logic [PW-1:0] cnt_nxt;

    assign cnt_nxt = st_q.count + 1'b1;
    // a command in this cycle overrides the tick for this channel
    assign expire  = tick && st_q.active && !cmd_hit && (cnt_nxt == st_q.period);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (cmd_hit) begin
            if (cmd_en) begin
                st_q.active  <= 1'b1;
                st_q.restart <= cmd_restart;
                st_q.period  <= cmd_period;
                st_q.count   <= '0;
            end else begin
                st_q.active <= 1'b0;
            end
        end else if (tick && st_q.active) begin
            if (expire) begin
                st_q.count <= '0;
                if (!st_q.restart) begin
                    st_q.active <= 1'b0;
                end
            end else begin
                st_q.count <= cnt_nxt;
            end
        end
    end
endmodule

// File: rtl/tick_timer_table.sv
module tick_timer_table
    import ttt_pkg::*;
#(
    parameter int N_TMR = ttt_pkg::NUM_TMR,
    parameter int TCW   = ttt_pkg::TCNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq
);
    ctrl_t            ctrl_q;
    logic             run_q;
    logic             tick;
    logic [N_TMR-1:0] evt_q;
    logic [N_TMR-1:0] mask_q;
    logic [TCW-1:0]   tick_cnt_q;
    logic [N_TMR-1:0] expire;
    logic [N_TMR-1:0] w1c;
    logic             cmd_wr;
    tmr_cmd_t         cmd;

    assign run_q  = ctrl_q.run;
    assign cmd_wr = wr_en && (addr == A_CMD);
    assign cmd    = decode_cmd(wdata);
    assign w1c    = (wr_en && addr == A_EVT) ? wdata[N_TMR-1:0] : '0;

    ttt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .div  (ctrl_q.div),
        .tick (tick)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_chan
        logic hit;
        assign hit = cmd_wr && (cmd.id == ID_W'(i));
        ttt_channel #(.PW(PERIOD_W)) u_chan (
            .clk         (clk),
            .rst         (rst),
            .tick        (tick),
            .cmd_hit     (hit),
            .cmd_en      (cmd.enable),
            .cmd_restart (cmd.restart),
            .cmd_period  (cmd.period),
            .expire      (expire[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            evt_q      <= '0;
            mask_q     <= '0;
            tick_cnt_q <= '0;
        end else begin
            if (wr_en && addr == A_CTRL) ctrl_q <= decode_ctrl(wdata);
            if (wr_en && addr == A_MASK) mask_q <= wdata[N_TMR-1:0];
            // a new expiry outranks a clear of the same bit
            evt_q <= (evt_q & ~w1c) | expire;
            if (wr_en && addr == A_TICKS) begin
                tick_cnt_q <= '0;
            end else if (tick) begin
                tick_cnt_q <= tick_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {ctrl_q.div, {(BUS_W-DIV_W-1){1'b0}}, ctrl_q.run};
            A_EVT:   rdata = BUS_W'(evt_q);
            A_MASK:  rdata = BUS_W'(mask_q);
            A_TICKS: rdata = BUS_W'(tick_cnt_q);
            default: rdata = '0;
        endcase
    end

    assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/ttt_checker.sv
module ttt_checker
    import ttt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [BUS_W-1:0] wdata,
    input logic             irq,
    input logic             run_q,
    input logic             tick,
    input logic [NUM_TMR-1:0] evt_q,
    input logic [NUM_TMR-1:0] mask_q,
    input logic [TCNT_W-1:0]  tick_cnt_q,
    input logic [NUM_TMR-1:0] expire
);
    // R3
    no_tick_halted_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> !tick);

    // R3
    expire_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (|expire) |-> tick);

    // R7
    evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && addr == A_EVT) && expire == '0) |=> $stable(evt_q));

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_EVT && expire == '0)
        |=> (evt_q & $past(wdata[NUM_TMR-1:0])) == '0);

    // R9
    irq_masked_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    // R10
    tick_cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_TICKS) |=> tick_cnt_q == '0);
endmodule

bind tick_timer_table ttt_checker u_ttt_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .irq        (irq),
    .run_q      (run_q),
    .tick       (tick),
    .evt_q      (evt_q),
    .mask_q     (mask_q),
    .tick_cnt_q (tick_cnt_q),
    .expire     (expire)
);

// File: tb/tb_tick_timer_table.sv
module tb_tick_timer_table;
    import ttt_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    tick_timer_table dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #5ns clk = ~clk;

    typedef struct packed {
        logic [3:0] id;
        logic [7:0] div;
        logic [7:0] period;
        logic       mask_on;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{id: 4'd0,  div: 8'd0, period: 8'd1, mask_on: 1'b1},
        '{id: 4'd15, div: 8'd2, period: 8'd3, mask_on: 1'b1},
        '{id: 4'd7,  div: 8'd1, period: 8'd5, mask_on: 1'b0},
        '{id: 4'd3,  div: 8'd4, period: 8'd2, mask_on: 1'b1},
        '{id: 4'd10, div: 8'd0, period: 8'd7, mask_on: 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the capture edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1ns;
        d = rdata;
    endtask

    function automatic logic [31:0] cmd_word(input int id, input bit en, input bit rs, input int per);
        return (32'(per) << 16) | (32'(rs) << 5) | (32'(en) << 4) | 32'(id);
    endfunction

    initial begin
        #1ms;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, d);  check("R1 ctrl", d, 0);
        rd(A_EVT, d);   check("R1 evt", d, 0);
        rd(A_MASK, d);  check("R1 mask", d, 0);
        rd(A_TICKS, d); check("R1 ticks", d, 0);
        check("R1 irq", 32'(irq), 0);

        // table walk: R2 timing, R4 command, R6 bit position, R9 irq
        for (int v = 0; v < NV; v++) begin
            int n;
            n = (int'(VECS[v].div) + 1) * int'(VECS[v].period);
            wr(A_MASK, VECS[v].mask_on ? (32'd1 << VECS[v].id) : 32'd0);
            wr(A_CMD, cmd_word(VECS[v].id, 1'b1, 1'b0, VECS[v].period));
            wr(A_CTRL, (32'(VECS[v].div) << 16) | 32'd1);
            repeat (n - 1) @(negedge clk);
            rd(A_EVT, d); check("R2 no event one edge early", d, 0);
            @(negedge clk);
            rd(A_EVT, d); check("R2 R4 R6 event on time", d, 32'd1 << VECS[v].id);
            check("R9 irq follows mask", 32'(irq), 32'(VECS[v].mask_on));
            wr(A_CTRL, 32'd0);
            wr(A_EVT, 32'hFFFF);
            wr(A_MASK, 32'd0);
            check("R9 irq low after clear", 32'(irq), 0);
        end

        // R8 auto-restart, R7 clear
        wr(A_CMD, cmd_word(2, 1'b1, 1'b1, 3));
        wr(A_CTRL, 32'd1);
        repeat (2) @(negedge clk);
        rd(A_EVT, d); check("R8 restart not yet", d, 0);
        @(negedge clk);
        rd(A_EVT, d); check("R8 restart first expiry", d, 32'h4);
        wr(A_EVT, 32'h4);
        rd(A_EVT, d); check("R7 write one clears", d, 0);
        @(negedge clk);
        rd(A_EVT, d); check("R8 restart gap", d, 0);
        @(negedge clk);
        rd(A_EVT, d); check("R8 restart second expiry", d, 32'h4);
        wr(A_CTRL, 32'd0);
        wr(A_EVT, 32'hFFFF_FFFB);
        rd(A_EVT, d); check("R7 write zero keeps bit", d, 32'h4);
        wr(A_EVT, 32'h4);
        wr(A_CMD, cmd_word(2, 1'b0, 1'b0, 0));

        // R8 one-shot fires once
        wr(A_CMD, cmd_word(6, 1'b1, 1'b0, 2));
        wr(A_CTRL, 32'd1);
        repeat (10) @(negedge clk);
        rd(A_EVT, d); check("R8 one-shot fired", d, 32'h40);
        wr(A_EVT, 32'h40);
        repeat (10) @(negedge clk);
        rd(A_EVT, d); check("R8 one-shot stays quiet", d, 0);
        wr(A_CTRL, 32'd0);

        // R5 disable ignores other fields
        wr(A_CMD, cmd_word(9, 1'b1, 1'b1, 2));
        wr(A_CMD, cmd_word(9, 1'b0, 1'b1, 1));
        wr(A_CTRL, 32'd1);
        repeat (20) @(negedge clk);
        rd(A_EVT, d); check("R5 disabled channel silent", d, 0);
        wr(A_CTRL, 32'd0);

        // R11 command on a tick cycle wins
        wr(A_CMD, cmd_word(5, 1'b1, 1'b0, 9));
        wr(A_CTRL, 32'd1);
        @(negedge clk);
        wr(A_CMD, cmd_word(5, 1'b1, 1'b0, 2));
        @(negedge clk);
        rd(A_EVT, d); check("R11 reload not yet", d, 0);
        @(negedge clk);
        rd(A_EVT, d); check("R11 reload fires on new period", d, 32'h20);
        wr(A_CTRL, 32'd0);

        // R9 mask gating with pending event on channel 5
        check("R9 masked irq low", 32'(irq), 0);
        wr(A_MASK, 32'h20);
        check("R9 unmasked irq high", 32'(irq), 1);
        wr(A_MASK, 32'h10);
        check("R9 other mask irq low", 32'(irq), 0);
        wr(A_MASK, 32'h20);
        wr(A_EVT, 32'h20);
        check("R9 irq drops on clear", 32'(irq), 0);
        wr(A_MASK, 32'd0);

        // R10 tick counter, R3 halt
        wr(A_TICKS, 32'd0);
        rd(A_TICKS, d); check("R10 cleared", d, 0);
        wr(A_CTRL, (32'd1 << 16) | 32'd1);
        repeat (10) @(negedge clk);
        rd(A_TICKS, d); check("R10 R2 tick count", d, 5);
        wr(A_TICKS, 32'hDEAD);
        rd(A_TICKS, d); check("R10 write clears", d, 0);
        wr(A_CTRL, 32'd0);
        rd(A_TICKS, held);
        wr(A_CMD, cmd_word(11, 1'b1, 1'b0, 1));
        repeat (20) @(negedge clk);
        rd(A_TICKS, d); check("R3 counter holds when halted", d, held);
        rd(A_EVT, d);   check("R3 channel frozen when halted", d, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule